// File: doc/BRIEF.md
# Line Error Counter Bank

This block keeps three performance-monitoring counters for an E1 receive path. One counts far-end block errors reported in the E-bits, and one counts CRC-4 check failures; each of these is 10 bits wide. The third is 16 bits wide and counts line-code violations that are not part of a legal HDB3 substitution. The framer and the line decoder each send a single-cycle pulse per error event. Each pulse adds exactly one to its counter.

Software reaches the counters through a byte-wide register port. It can read any counter byte by byte, and it can preset or clear a counter with two writes. The low byte goes first and is held in a staging register. The high-byte write then loads both bytes at once, so a half-written value never counts.

Every increment changes the lowest bit of the count, and each increment sets a sticky "toggle" status bit. An increment from all ones to zero also sets a separate sticky "wrap" status bit. A mask register selects which status bits drive the single interrupt output.

Top module: `line_err_ctr_bank`

## Requirements
- R1: The E-bit counter (addresses 0 low, 1 high) and the CRC-4 counter (addresses 4 low, 5 high) are 10 bits wide. Each adds one per pulse on its error input and wraps from 0x3FF to 0x000.
- R2: The violation counter (addresses 2 low, 3 high) is 16 bits wide. It adds one per pulse on its error input and wraps from 0xFFFF to 0x0000.
- R3: A pulse in one cycle shows in the count read back in the next cycle. Pulses arriving together on different counters are each counted independently.
- R4: Reads are combinational on the address. A low address returns count bits 7:0. A high address returns the bits above bit 7, with the unused upper positions of a 10-bit counter read as zero.
- R5: A write to a counter's low address only fills that counter's staging register; the count itself does not change.
- R6: A write to a counter's high address loads {written byte, staged byte} into the counter in one step, truncated to the counter's width.
- R7: If an error pulse arrives in the same cycle as a high-byte write to that counter, the loaded value is kept and that increment is dropped.
- R8: Status bit 2k is set by every increment of counter k (E-bit k=0, violation k=1, CRC-4 k=2), since each increment changes the lowest bit. A preset does not set any status bit.
- R9: Status bit 2k+1 is set when counter k increments from all ones to zero.
- R10: Status bits at address 6 stay set until software writes 1 to them. Writing 0 leaves a bit unchanged. A set event in the same cycle as a clearing write keeps the bit set.
- R11: The mask register at address 7 is read/write with 6 valid bits. irq_o is high exactly when some status bit and its mask bit are both 1.
- R12: After reset, all counts, staging registers, status bits and mask bits are zero and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ebit_err_i | input | 1 | Far-end block error pulse |
| bpv_err_i | input | 1 | Line-code violation pulse |
| crc_err_i | input | 1 | CRC-4 error pulse |
| bus_addr_i | input | 3 | Register address |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The counters are driven with isolated pulses, with bursts on one input, and with pulses on all three inputs in the same cycle. These patterns separate counting from crosstalk between counters. Presets just below all ones push each width across its wrap. This exposes a wrong width, a missing wrap flag, or a wrap flag raised one count early. Two kinds of collision are applied: an error pulse together with a high-byte load, and a status set together with a clearing write. These pin down which side wins. The bench also checks that a lone low-byte write leaves the count unchanged. Masks are swept so that the interrupt is seen both gated and passed for a single status source.

// File: rtl/lec_pkg.sv
package lec_pkg;
    localparam int ADDR_W    = 3;
    localparam int NUM_CTR   = 3;
    localparam int BLK_W     = 10;
    localparam int VIOL_W    = 16;
    localparam int CTR_MAXW  = 16;
    localparam int NUM_STAT  = 2 * NUM_CTR;

    localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd6;
    localparam logic [ADDR_W-1:0] ADDR_MASK   = 3'd7;

    typedef enum logic [1:0] {
        CTR_EBIT = 2'd0,
        CTR_VIOL = 2'd1,
        CTR_CRC  = 2'd2
    } ctr_id_e;

    function automatic int ctr_width(input int idx);
        return (idx == int'(CTR_VIOL)) ? VIOL_W : BLK_W;
    endfunction
endpackage

// File: rtl/lec_err_counter.sv
module lec_err_counter #(
    parameter int WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_i,
    input  logic             lo_wr_i,
    input  logic             hi_wr_i,
    input  logic [7:0]       wdata_i,
    output logic [WIDTH-1:0] cnt_o,
    output logic             tog_o,
    output logic             wrap_o
);
    localparam int HI_W = WIDTH - 8;
    localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);
    localparam logic [WIDTH-1:0] ALL_ONES = '1;

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
        logic [7:0]       stage;
    } ctr_state_t;

    ctr_state_t st_d, st_q;
    logic tog_d, wrap_d;

    always_comb begin
        st_d   = st_q;
        tog_d  = 1'b0;
        wrap_d = 1'b0;
        if (lo_wr_i) begin
            st_d.stage = wdata_i;
        end
        if (hi_wr_i) begin
            st_d.cnt = {wdata_i[HI_W-1:0], st_q.stage};
        end else if (err_i) begin
            st_d.cnt = st_q.cnt + ONE;
            tog_d    = 1'b1;
            wrap_d   = (st_q.cnt == ALL_ONES);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign tog_o  = tog_d;
    assign wrap_o = wrap_d;

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_i && !hi_wr_i) |=> (cnt_o == $past(cnt_o) + ONE)); // R1
    AST_STAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr_i && !err_i) |=> $stable(cnt_o)); // R5
    AST_PRESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr_i |=> (cnt_o == {$past(wdata_i[HI_W-1:0]), $past(st_q.stage)})); // R7
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_o == '0)); // R9
endmodule

// File: rtl/lec_irq_status.sv
module lec_irq_status #(
    parameter int N_SRC = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set_i,
    input  logic             clr_wr_i,
    input  logic             msk_wr_i,
    input  logic [7:0]       wdata_i,
    output logic [N_SRC-1:0] status_o,
    output logic [N_SRC-1:0] mask_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [N_SRC-1:0] status;
        logic [N_SRC-1:0] mask;
    } irq_state_t;

    irq_state_t st_d, st_q;
    logic [N_SRC-1:0] clr_bits;

    always_comb begin
        st_d     = st_q;
        clr_bits = clr_wr_i ? wdata_i[N_SRC-1:0] : '0;
        st_d.status = (st_q.status & ~clr_bits) | set_i;
        if (msk_wr_i) begin
            st_d.mask = wdata_i[N_SRC-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;
    assign mask_o   = st_q.mask;
    assign irq_o    = |(st_q.status & st_q.mask);

    AST_STICKY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr_i |=> ((status_o & $past(status_o)) == $past(status_o))); // R10
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((status_o & $past(set_i)) == $past(set_i))); // R10
    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_o == '0) |-> !irq_o); // R11
endmodule

// File: rtl/line_err_ctr_bank.sv
module line_err_ctr_bank
    import lec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ebit_err_i,
    input  logic              bpv_err_i,
    input  logic              crc_err_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o,
    output logic              irq_o
);
    logic [NUM_CTR-1:0]  err_vec;
    logic [NUM_CTR-1:0]  lo_wr, hi_wr;
    logic [NUM_CTR-1:0]  tog_ev, wrap_ev;
    logic [CTR_MAXW-1:0] cnt_ext [NUM_CTR];
    logic [NUM_STAT-1:0] set_vec, status, mask;
    logic                clr_wr, msk_wr;

    assign err_vec = {crc_err_i, bpv_err_i, ebit_err_i};
    assign clr_wr  = bus_wr_i && (bus_addr_i == ADDR_STATUS);
    assign msk_wr  = bus_wr_i && (bus_addr_i == ADDR_MASK);

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        localparam int CW = ctr_width(g);
        localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(2 * g);
        localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(2 * g + 1);
        logic [CW-1:0] cnt;

        assign lo_wr[g] = bus_wr_i && (bus_addr_i == LO_ADDR);
        assign hi_wr[g] = bus_wr_i && (bus_addr_i == HI_ADDR);

        lec_err_counter #(.WIDTH(CW)) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .err_i   (err_vec[g]),
            .lo_wr_i (lo_wr[g]),
            .hi_wr_i (hi_wr[g]),
            .wdata_i (bus_wdata_i),
            .cnt_o   (cnt),
            .tog_o   (tog_ev[g]),
            .wrap_o  (wrap_ev[g])
        );

        always_comb begin
            cnt_ext[g]         = '0;
            cnt_ext[g][CW-1:0] = cnt;
        end

        assign set_vec[2*g]   = tog_ev[g];
        assign set_vec[2*g+1] = wrap_ev[g];
    end

    lec_irq_status #(.N_SRC(NUM_STAT)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_vec),
        .clr_wr_i (clr_wr),
        .msk_wr_i (msk_wr),
        .wdata_i  (bus_wdata_i),
        .status_o (status),
        .mask_o   (mask),
        .irq_o    (irq_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == ADDR_STATUS) begin
            bus_rdata_o[NUM_STAT-1:0] = status;
        end else if (bus_addr_i == ADDR_MASK) begin
            bus_rdata_o[NUM_STAT-1:0] = mask;
        end else begin
            for (int k = 0; k < NUM_CTR; k++) begin
                if (bus_addr_i[ADDR_W-1:1] == (ADDR_W-1)'(k)) begin
                    bus_rdata_o = bus_addr_i[0] ? cnt_ext[k][15:8] : cnt_ext[k][7:0];
                end
            end
        end
    end

    AST_ONE_CYCLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (ebit_err_i && !hi_wr[0]) |=> status[0]); // R3
    AST_PRESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_wr[1] && !clr_wr) |=> (status[2] == $past(status[2]))); // R8
endmodule

// File: tb/line_err_ctr_bank_tb_top.sv
module line_err_ctr_bank_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       ebit, bpv, crc;
    logic [2:0] addr;
    logic       wr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       irq;

    always #5 clk = ~clk;

    line_err_ctr_bank dut_i (
        .clk(clk), .rst_n(rst_n), .ebit_err_i(ebit), .bpv_err_i(bpv),
        .crc_err_i(crc), .bus_addr_i(addr), .bus_wr_i(wr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // behavioural reference model
    int m_cnt[3];
    int m_stage[3];
    int m_stat;
    int m_mask;
    int m_w[3] = '{10, 16, 10};

    function automatic int m_read(input int a);
        if (a < 6) return (a % 2) ? ((m_cnt[a/2] >> 8) & 255) : (m_cnt[a/2] & 255);
        if (a == 6) return m_stat;
        return m_mask;
    endfunction

    always @(posedge clk) begin : model
        int setb;
        int maxv;
        bit errv[3];
        if (!rst_n) begin
            for (int k = 0; k < 3; k++) begin m_cnt[k] = 0; m_stage[k] = 0; end
            m_stat = 0;
            m_mask = 0;
        end else begin
            setb = 0;
            errv[0] = ebit; errv[1] = bpv; errv[2] = crc;
            for (int k = 0; k < 3; k++) begin
                maxv = (1 << m_w[k]) - 1;
                if (wr && addr == 3'(2*k+1)) begin
                    m_cnt[k] = ((int'(wdata) << 8) | m_stage[k]) & maxv;
                end else if (errv[k]) begin
                    if (m_cnt[k] == maxv) setb |= (2 << (2*k));
                    m_cnt[k] = (m_cnt[k] + 1) & maxv;
                    setb |= (1 << (2*k));
                end
                if (wr && addr == 3'(2*k)) m_stage[k] = int'(wdata);
            end
            if (wr && addr == 3'd6) m_stat &= ~int'(wdata);
            m_stat = (m_stat | setb) & 63;
            if (wr && addr == 3'd7) m_mask = int'(wdata) & 63;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk(int'(rdata) == m_read(int'(addr)), "R4 model read", int'(rdata), m_read(int'(addr)));
            chk(irq == ((m_stat & m_mask) != 0), "R11 model irq", int'(irq), int'((m_stat & m_mask) != 0));
        end
    end

    task automatic cyc(input bit e, input bit b, input bit c, input bit w,
                       input int a, input int d);
        @(negedge clk);
        ebit = e; bpv = b; crc = c; wr = w; addr = 3'(a); wdata = 8'(d);
        @(negedge clk);
        ebit = 0; bpv = 0; crc = 0; wr = 0;
    endtask

    task automatic bwr(input int a, input int d);
        cyc(0, 0, 0, 1, a, d);
    endtask

    task automatic rd(input int a, input int exp, input string req);
        @(negedge clk);
        addr = 3'(a);
        #1;
        chk(int'(rdata) == exp, req, int'(rdata), exp);
    endtask

    task automatic irq_is(input bit exp, input string req);
        @(negedge clk);
        #1;
        chk(irq == exp, req, int'(irq), int'(exp));
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog timeout");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 0; ebit = 0; bpv = 0; crc = 0; wr = 0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R12 reset state
        for (int a = 0; a < 8; a++) rd(a, 0, "R12 reset register");
        irq_is(0, "R12 reset irq");

        // R1 R3 R8 single pulses
        repeat (3) cyc(1, 0, 0, 0, 0, 0);
        rd(0, 3, "R1 ebit count");
        rd(1, 0, "R4 ebit high");
        rd(6, 8'h01, "R8 ebit toggle status");

        // R3 simultaneous pulses
        cyc(1, 1, 1, 0, 0, 0);
        rd(0, 4, "R3 ebit together");
        rd(2, 1, "R3 viol together");
        rd(4, 1, "R3 crc together");
        rd(6, 8'h15, "R8 all toggle bits");

        // R10 clear all
        bwr(6, 8'hFF);
        rd(6, 0, "R10 full clear");

        // R4 zero-fill of upper bits
        bwr(0, 8'h00);
        bwr(1, 8'hFF);
        rd(1, 8'h03, "R4 high byte zero fill");
        rd(6, 0, "R8 preset sets no status");

        // R5 R6 staged preset
        bwr(0, 8'hFE);
        rd(0, 8'h00, "R5 low write alone no effect");
        rd(1, 8'h03, "R5 high unchanged");
        bwr(1, 8'h03);
        rd(0, 8'hFE, "R6 loaded low");
        rd(1, 8'h03, "R6 loaded high");

        // R1 R9 wrap of 10-bit
        cyc(1, 0, 0, 0, 0, 0);
        rd(6, 8'h01, "R9 no wrap at 3FF");
        cyc(1, 0, 0, 0, 0, 0);
        rd(0, 0, "R1 wrap low");
        rd(1, 0, "R1 wrap high");
        rd(6, 8'h03, "R9 ebit wrap status");

        // R2 R9 16-bit wrap
        bwr(2, 8'hFF);
        bwr(3, 8'hFF);
        rd(3, 8'hFF, "R2 full high byte");
        cyc(0, 1, 0, 0, 0, 0);
        rd(2, 0, "R2 wrap low");
        rd(3, 0, "R2 wrap high");
        rd(6, 8'h0F, "R9 viol wrap status");

        // R10 partial clear and set-wins
        bwr(6, 8'h01);
        rd(6, 8'h0E, "R10 partial clear");
        cyc(1, 0, 0, 1, 6, 8'h01);
        rd(6, 8'h0F, "R10 set wins over clear");

        // R11 masking
        irq_is(0, "R11 mask zero");
        bwr(7, 8'h20);
        irq_is(0, "R11 unrelated mask");
        rd(7, 8'h20, "R11 mask readback");
        bwr(7, 8'h01);
        irq_is(1, "R11 masked source");
        bwr(6, 8'h01);
        irq_is(0, "R11 cleared source");

        // R7 collision
        bwr(6, 8'hFF);
        bwr(4, 8'h55);
        cyc(0, 0, 1, 1, 5, 8'h01);
        rd(4, 8'h55, "R7 preset wins low");
        rd(5, 8'h01, "R7 preset wins high");
        rd(6, 0, "R7 dropped increment no status");

        // R1 R9 crc wrap
        bwr(4, 8'hFF);
        bwr(5, 8'h03);
        cyc(0, 0, 1, 0, 0, 0);
        rd(4, 0, "R1 crc wrap");
        rd(6, 8'h30, "R9 crc wrap status");
        bwr(7, 8'h20);
        irq_is(1, "R11 crc wrap irq");

        // R12 reset mid-run
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        rd(6, 0, "R12 status after reset");
        rd(7, 0, "R12 mask after reset");
        rd(2, 0, "R12 count after reset");
        bwr(1, 8'h01);
        rd(0, 0, "R12 staging cleared");

        done = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule